// File: doc/BRIEF.md
# Cross-Domain Poison Interrupt Status

This block collects transaction-poisoning indications from a set of fabric ports. Each port has one indication for its read address channel and one for its write address channel. Each indication sets a sticky flag in the fabric clock domain. A two-flop synchronizer carries the flags into the register-bus (APB) clock domain. There they form a read-only status word and a combined interrupt line.

Software clears flags by writing per-port masks to two clear registers, one for the read class and one for the write class. A clear request crosses into the fabric domain as a toggle and clears the selected flags there. It is then acknowledged back across to the bus domain. The cleared state becomes visible only when the flags have passed back through the status synchronizer. A clear register accepts one request at a time.

Top module: `poison_irq_status`

## Requirements
- R1: The status word at offset 0x00 carries the write-class flag of port p in bit p and the read-class flag of port p in bit 16+p, for ports 0 to 5.
- R2: A fabric-clock cycle with a poison input at 1 sets that flag. The flag stays set after the input returns to 0, until it is cleared.
- R3: After reset every status bit reads 0 and `irq_o` is 0.
- R4: Status bits 6 to 15 and 22 to 31 read 0, and the clear registers read 0. An APB write to offset 0x00 changes nothing. `pready` is always 1 and `pslverr` is always 0.
- R5: Writing a mask to offset 0x08 clears the read-class flag of every port p whose bit p (bits 5:0) is 1. Zero bits leave flags unchanged, and write-class flags are untouched.
- R6: Writing a mask to offset 0x04 clears the write-class flag of every port p whose bit p is 1. Read-class flags are untouched.
- R7: A clear write that arrives while an earlier clear of the same class is still pending is discarded. A clear written after the earlier one has completed is accepted.
- R8: If a poison event and a clear for the same flag fall in the same fabric-clock cycle, the flag stays set. It does not drop even for one cycle.
- R9: `irq_o` is 1 exactly when any synchronized status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fab_clk | input | 1 | Fabric (port) domain clock |
| fab_rst | input | 1 | Synchronous active-high reset, fabric domain |
| wr_poison_i | input | 6 | Per-port write-address-channel poison indication |
| rd_poison_i | input | 6 | Per-port read-address-channel poison indication |
| pclk | input | 1 | Register-bus clock |
| prst | input | 1 | Synchronous active-high reset, bus domain |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| irq_o | output | 1 | Combined poison interrupt, bus domain |

## Verification
The collision that matters is a clear reaching the fabric domain in the same cycle as a poison event on the same port. The bench provokes it by holding one port's poison input high for the whole clear round trip, so an event is present in whichever fabric cycle the clear lands. All other flags are cleared first, so `irq_o` reflects that one flag alone. The bench samples `irq_o` every bus cycle through the window. Any dip means the clear won.

The second overlap is a clear write that arrives while the previous clear of the same class is still in flight. It is judged by which flags remain set once both have settled.

// File: rtl/poison_status_pkg.sv
package poison_status_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_W    = 8;
    localparam int MAX_PORTS = 16;
    localparam int RD_BASE   = 16;

    typedef enum logic [0:0] {
        CLS_WR = 1'b0,
        CLS_RD = 1'b1
    } poison_cls_e;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_WCLR   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_RCLR   = 8'h08;

    typedef struct packed {
        logic              wr_en;
        logic              rd_en;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
    } bus_req_t;

    function automatic logic [ADDR_W-1:0] clr_offset(input poison_cls_e c);
        return (c == CLS_RD) ? OFF_RCLR : OFF_WCLR;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(
        input logic [MAX_PORTS-1:0] wr_flags,
        input logic [MAX_PORTS-1:0] rd_flags
    );
        logic [REG_W-1:0] w;
        w = '0;
        w[MAX_PORTS-1:0]               = wr_flags;
        w[RD_BASE+MAX_PORTS-1:RD_BASE] = rd_flags;
        return w;
    endfunction

endpackage

// File: rtl/cdc_sync_vec.sv
module cdc_sync_vec #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/poison_flag_bank.sv
module poison_flag_bank #(
    parameter int NP = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] ev_i,
    input  logic          req_tog_i,
    input  logic [NP-1:0] mask_i,
    output logic [NP-1:0] flags_o,
    output logic          ack_tog_o
);
    logic          req_sync;
    logic          req_seen_q;
    logic          fire;
    logic [NP-1:0] flags_q;
    logic          ack_q;

    cdc_sync_vec #(.W(1)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d_i (req_tog_i),
        .q_o (req_sync)
    );

    assign fire = req_sync ^ req_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_seen_q <= 1'b0;
            ack_q      <= 1'b0;
            flags_q    <= '0;
        end else begin
            req_seen_q <= req_sync;
            if (fire) begin
                ack_q   <= ~ack_q;
                flags_q <= (flags_q & ~mask_i) | ev_i;
            end else begin
                flags_q <= flags_q | ev_i;
            end
        end
    end

    assign flags_o   = flags_q;
    assign ack_tog_o = ack_q;

    // R8
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|ev_i) |=> ((flags_q & $past(ev_i)) == $past(ev_i)));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/poison_clr_requester.sv
module poison_clr_requester #(
    parameter int NP = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit_i,
    input  logic [NP-1:0] wdata_i,
    input  logic          ack_tog_i,
    output logic          req_tog_o,
    output logic [NP-1:0] mask_o
);
    logic          ack_sync;
    logic          ack_seen_q;
    logic          ack_edge;
    logic          busy_q;
    logic          tog_q;
    logic [NP-1:0] mask_q;
    logic          start;

    cdc_sync_vec #(.W(1)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ack_tog_i),
        .q_o (ack_sync)
    );

    assign ack_edge = ack_sync ^ ack_seen_q;
    assign start    = hit_i && !busy_q && (|wdata_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_seen_q <= 1'b0;
            busy_q     <= 1'b0;
            tog_q      <= 1'b0;
            mask_q     <= '0;
        end else begin
            ack_seen_q <= ack_sync;
            if (start) begin
                mask_q <= wdata_i;
                tog_q  <= ~tog_q;
                busy_q <= 1'b1;
            end else if (ack_edge) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign req_tog_o = tog_q;
    assign mask_o    = mask_q;

    // R7
    mask_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !ack_edge) |=> (busy_q && $stable(mask_q)));

    // R7
    idle_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!hit_i || busy_q) |=> $stable(tog_q));
endmodule

// File: rtl/poison_irq_status.sv
module poison_irq_status
    import poison_status_pkg::*;
#(
    parameter int NP = 6
) (
    input  logic              fab_clk,
    input  logic              fab_rst,
    input  logic [NP-1:0]     wr_poison_i,
    input  logic [NP-1:0]     rd_poison_i,
    input  logic              pclk,
    input  logic              prst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [REG_W-1:0]  pwdata,
    output logic [REG_W-1:0]  prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq_o
);
    localparam int NCLS = 2;

    bus_req_t      req;
    logic [NP-1:0] ev_arr    [NCLS];
    logic [NP-1:0] flags_arr [NCLS];
    logic [NP-1:0] mask_arr  [NCLS];
    logic          rtog_arr  [NCLS];
    logic          atog_arr  [NCLS];
    logic [2*NP-1:0] st_sync;
    logic [NP-1:0] st_wr;
    logic [NP-1:0] st_rd;
    logic [REG_W-1:0] status_word;

    assign req.wr_en = psel && penable && pwrite;
    assign req.rd_en = psel && !pwrite;
    assign req.addr  = paddr;
    assign req.wdata = pwdata;

    assign ev_arr[CLS_WR] = wr_poison_i;
    assign ev_arr[CLS_RD] = rd_poison_i;

    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        logic hit;
        assign hit = req.wr_en && (req.addr == clr_offset(poison_cls_e'(g)));

        poison_clr_requester #(.NP(NP)) u_req (
            .clk       (pclk),
            .rst       (prst),
            .hit_i     (hit),
            .wdata_i   (req.wdata[NP-1:0]),
            .ack_tog_i (atog_arr[g]),
            .req_tog_o (rtog_arr[g]),
            .mask_o    (mask_arr[g])
        );

        poison_flag_bank #(.NP(NP)) u_bank (
            .clk       (fab_clk),
            .rst       (fab_rst),
            .ev_i      (ev_arr[g]),
            .req_tog_i (rtog_arr[g]),
            .mask_i    (mask_arr[g]),
            .flags_o   (flags_arr[g]),
            .ack_tog_o (atog_arr[g])
        );
    end

    cdc_sync_vec #(.W(2*NP)) u_status_sync (
        .clk (pclk),
        .rst (prst),
        .d_i ({flags_arr[CLS_RD], flags_arr[CLS_WR]}),
        .q_o (st_sync)
    );

    assign st_wr       = st_sync[NP-1:0];
    assign st_rd       = st_sync[2*NP-1:NP];
    assign status_word = pack_status(MAX_PORTS'(st_wr), MAX_PORTS'(st_rd));

    assign prdata  = (req.rd_en && req.addr == OFF_STATUS) ? status_word : '0;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq_o   = |st_sync;
endmodule

// File: tb/sim_poison_irq_status.sv
module sim_poison_irq_status;
    logic        fab_clk = 0, fab_rst = 1;
    logic        pclk = 0, prst = 1;
    logic [5:0]  wr_poison_i = '0, rd_poison_i = '0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq_o;

    int checks = 0, errors = 0;
    logic [5:0] exp_wr = '0, exp_rd = '0;
    logic [31:0] rd_val;
    logic        dipped;
    logic        err_seen;

    always #4 pclk = ~pclk;
    always #8 fab_clk = ~fab_clk;

    poison_irq_status #(.NP(6)) u0 (
        .fab_clk(fab_clk), .fab_rst(fab_rst),
        .wr_poison_i(wr_poison_i), .rd_poison_i(rd_poison_i),
        .pclk(pclk), .prst(prst),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_word(input logic [5:0] w, input logic [5:0] r);
        return (32'(r) << 16) | 32'(w);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1;
        if (pslverr !== 1'b0 || pready !== 1'b1) err_seen = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        d = prdata;
        if (pslverr !== 1'b0 || pready !== 1'b1) err_seen = 1;
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic settle();
        repeat (20) @(negedge pclk);
    endtask

    task automatic pulse(input bit rd, input int p);
        @(negedge fab_clk);
        if (rd) rd_poison_i[p] = 1'b1; else wr_poison_i[p] = 1'b1;
        @(negedge fab_clk);
        rd_poison_i = '0; wr_poison_i = '0;
    endtask

    task automatic status_check(input string req);
        apb_read(8'h00, rd_val);
        check(req, rd_val, exp_word(exp_wr, exp_rd));
        @(negedge pclk);
        check("R9 irq", 32'(irq_o), 32'((|exp_wr) | (|exp_rd)));
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        err_seen = 0;
        repeat (4) @(negedge pclk);
        fab_rst = 0; prst = 0;
        repeat (4) @(negedge pclk);

        // R3 reset state
        apb_read(8'h00, rd_val);
        check("R3 status", rd_val, 32'h0);
        check("R3 irq", 32'(irq_o), 32'h0);

        // R1 R2 R9 sweep over every port and both classes
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 6; p++) begin
                pulse(c[0], p);
                settle();
                if (c == 1) exp_rd[p] = 1'b1; else exp_wr[p] = 1'b1;
                status_check(c == 1 ? "R1 R2 rd sweep" : "R1 R2 wr sweep");
            end
        end

        // R4 write to status ignored, unused bits zero, clear regs read 0
        apb_write(8'h00, 32'h0);
        settle();
        status_check("R4 status write ignored");
        apb_read(8'h04, rd_val);
        check("R4 wclr reads 0", rd_val, 32'h0);
        apb_read(8'h08, rd_val);
        check("R4 rclr reads 0", rd_val, 32'h0);

        // R5 zero mask has no effect
        apb_write(8'h08, 32'h0);
        settle();
        status_check("R5 zero mask");

        // R5 read clear, write flags untouched
        apb_write(8'h08, 32'h15);
        settle();
        exp_rd &= ~6'h15;
        status_check("R5 read clear");

        // R6 write clear, read flags untouched
        apb_write(8'h04, 32'h2A);
        settle();
        exp_wr &= ~6'h2A;
        status_check("R6 write clear");

        // R7 second clear while first pending is discarded
        apb_write(8'h08, 32'h02);
        apb_write(8'h08, 32'h08);
        settle();
        exp_rd &= ~6'h02;
        status_check("R7 pending clear dropped");
        apb_write(8'h08, 32'h08);
        settle();
        exp_rd &= ~6'h08;
        status_check("R7 later clear accepted");

        // leave only write flag of port 0
        apb_write(8'h08, 32'h3F);
        settle();
        apb_write(8'h04, 32'h3E);
        settle();
        exp_rd = '0; exp_wr = 6'h01;
        status_check("R6 partial clear");

        // R8 event held through the clear window
        @(negedge fab_clk);
        wr_poison_i[0] = 1'b1;
        repeat (2) @(negedge fab_clk);
        dipped = 0;
        apb_write(8'h04, 32'h01);
        for (int i = 0; i < 40; i++) begin
            @(negedge pclk);
            if (irq_o !== 1'b1) dipped = 1;
        end
        check("R8 no dip during collision", 32'(dipped), 32'h0);
        @(negedge fab_clk);
        wr_poison_i = '0;
        settle();
        status_check("R8 flag kept");

        // R6 R9 final clear drops irq
        apb_write(8'h04, 32'h01);
        settle();
        exp_wr = '0;
        status_check("R9 all clear");

        check("R4 pready/pslverr", 32'(err_seen), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule